// File: doc/BRIEF.md
# Two-Wire Addressed Memory Slave

This block is a serial slave for a two-wire bus with clock (SCL) and data (SDA) lines. It opens a 256-location byte space to a bus master. The space holds a nonvolatile array, a small bank of volatile control registers, one read-only status byte and a reserved window. The block oversamples both bus lines with its own clock and detects START and STOP conditions. It matches a 7-bit device address, of which the low three bits come from strap pins. It then takes a one-byte word address. Every byte is shifted most significant bit first.

Masters use byte or page writes and current-address, random or sequential reads. Writes pass three gates: a write-enable latch, a write-protect pin and a block-lock field. Nonvolatile data is collected in a one-page buffer and written into the array only at a STOP that ends on a byte boundary. A busy counter then models the programming time. While that counter runs, the device address is not acknowledged, so the master can poll for completion. Writes to volatile registers take effect as each byte is acknowledged.

Top module: `tw_mem_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {DEV_ID (default 4'b1010), strap_i}; bit 0 selects read (1) or write (0). On a mismatch it leaves SDA released for the rest of the transfer, and it raises sda_oe only while SCL is low.
- R2: Bytes move MSB first. A random read is START, address byte with bit0=0, word address, repeated START, address byte with bit0=1; the slave acknowledges all three bytes and then returns the byte at the word address.
- R3: In a write, each acknowledged data byte goes to the current pointer. The low four pointer bits then increment and wrap from 15 to 0, while the upper four bits never change.
- R4: In a read, the slave sends the next byte for every master acknowledge, and the pointer wraps from FFh to 00h. A master non-acknowledge ends the transfer.
- R5: After any read byte the pointer has advanced past it, so a current-address read returns the following location.
- R6: Register 86h bit 7 is the write-enable latch, and reset clears it. Writing exactly 80h sets the latch and writing exactly 00h clears it; neither changes bits 6:0. Any other value written to 86h updates bits 6:0 only while the latch is set. While the latch is clear, data bytes to every other location are acknowledged and discarded.
- R7: While wp_i is high, every data byte is discarded, including 80h/00h to 86h, and no nonvolatile commit starts.
- R8: Register 86h bits 1:0 lock nonvolatile locations against writes: 01 locks 00h–3Fh, 10 locks 00h–7Fh, 11 locks all of 00h–7Fh and 90h–FFh. Locations 80h–8Fh are never locked.
- R9: Buffered nonvolatile bytes (00h–7Fh, 90h–FFh) are committed only by a STOP that follows a whole number of acknowledged data bytes. A STOP inside a byte discards them, and busy_o stays low.
- R10: Writes to volatile registers 80h–86h take effect immediately, and busy_o does not rise.
- R11: A commit holds busy_o high for BUSY_CYC clocks. During that time the device address is not acknowledged; afterwards it is.
- R12: Address 87h reads sense_i and ignores writes. Writes to 88h–8Fh are acknowledged and discarded, and those addresses read 00h.
- R13: After reset sda_oe and busy_o are low and the nonvolatile array reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write protect, high refuses all writes |
| sense_i | input | 8 | Value returned when 87h is read |
| busy_o | output | 1 | Nonvolatile commit in progress |

## Verification
Two events can overlap here. One is the STOP that commits a page and loads the busy counter. The other is the address decision of the next transfer, which must see that counter. The bench sends an address poll straight after the committing STOP and expects a non-acknowledge while busy_o is high. After busy_o falls, the same poll must be acknowledged. A second overlap is a STOP that lands inside a partly clocked byte while a page is buffered. The bench judges it by reading the locations back unchanged and by checking that busy_o never rose.

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
  parameter logic [3:0] DEV_ID   = 4'b1010,
  parameter int         BUSY_CYC = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  input  logic [7:0] sense_i,
  output logic       busy_o
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WA, S_WD, S_RD} st_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] bitcnt;
  logic       ackph;
  logic [7:0] shreg, ptr, tx;
  logic [7:0] mem  [256];
  logic [7:0] vreg [8];
  logic [7:0] pbuf [16];
  logic [15:0] pv;
  logic [3:0] pbase;
  logic [BW-1:0] bcnt;

  wire scl_s = scl_m[1];
  wire sda_s = sda_m[1];
  wire rise  = scl_s & ~scl_q;
  wire fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  wire       latch = vreg[6][7];
  wire [1:0] lockf = vreg[6][1:0];
  wire       is_vol = ptr[7:4] == 4'h8;
  wire       locked = !is_vol && (lockf == 2'd3 ||
                      (lockf == 2'd2 && !ptr[7]) ||
                      (lockf == 2'd1 && ptr[7:6] == 2'b00));
  wire       wr_ok    = !wp_i && latch && !locked;
  wire       latch_op = ptr == 8'h86 && (shreg == 8'h80 || shreg == 8'h00) && !wp_i;
  wire       wr_stb   = fall && !ackph && st == S_WD && bitcnt == 4'd8;
  wire       dev_hit  = shreg[7:1] == {DEV_ID, strap_i};

  assign busy_o = bcnt != '0;

  function automatic logic [7:0] rd_fn(input logic [7:0] a);
    if (a[7:4] != 4'h8) return mem[a];
    if (a[3])           return 8'h00;
    if (a[2:0] == 3'd7) return sense_i;
    return vreg[a[2:0]];
  endfunction

  wire [7:0] rd_cur = rd_fn(ptr);
  wire [7:0] rd_nxt = rd_fn(ptr + 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      ackph  <= 1'b0;
      shreg  <= '0;
      ptr    <= '0;
      tx     <= '0;
      sda_oe <= 1'b0;
      pv     <= '0;
      pbase  <= '0;
      bcnt   <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      for (int i = 0; i < 8; i++)   vreg[i] <= '0;
      for (int i = 0; i < 16; i++)  pbuf[i] <= '0;
    end else begin
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (start_det) begin
        st <= S_DEV;
        bitcnt <= '0;
        ackph <= 1'b0;
        sda_oe <= 1'b0;
        pv <= '0;
      end else if (stop_det) begin
        if (st == S_WD && bitcnt == 4'd1 && !ackph && pv != '0 && !wp_i) begin
          for (int i = 0; i < 16; i++)
            if (pv[i]) mem[{pbase, 4'(i)}] <= pbuf[i];
          bcnt <= BW'(BUSY_CYC);
        end
        st <= S_IDLE;
        bitcnt <= '0;
        ackph <= 1'b0;
        sda_oe <= 1'b0;
        pv <= '0;
      end else if (rise && !ackph) begin
        if (st == S_RD) begin
          if (bitcnt != 4'd8) bitcnt <= bitcnt + 4'd1;
          else begin
            bitcnt <= '0;
            ptr <= ptr + 8'd1;
            if (sda_s) st <= S_IDLE;
            else       tx <= rd_nxt;
          end
        end else if (st != S_IDLE && bitcnt != 4'd8) begin
          shreg <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
      end else if (fall) begin
        if (ackph) begin
          ackph <= 1'b0;
          bitcnt <= '0;
          if (st == S_RD) begin
            tx <= rd_cur;
            sda_oe <= ~rd_cur[7];
          end else sda_oe <= 1'b0;
        end else if (st == S_RD) begin
          sda_oe <= (bitcnt != 4'd8) ? ~tx[~bitcnt[2:0]] : 1'b0;
        end else if (st != S_IDLE && bitcnt == 4'd8) begin
          case (st)
            S_DEV: begin
              if (dev_hit && !busy_o) begin
                ackph <= 1'b1;
                sda_oe <= 1'b1;
                st <= shreg[0] ? S_RD : S_WA;
              end else begin
                st <= S_IDLE;
                bitcnt <= '0;
              end
            end
            S_WA: begin
              ptr <= shreg;
              ackph <= 1'b1;
              sda_oe <= 1'b1;
              st <= S_WD;
            end
            default: begin
              ackph <= 1'b1;
              sda_oe <= 1'b1;
              ptr <= {ptr[7:4], ptr[3:0] + 4'd1};
              if (is_vol) begin
                if (latch_op) vreg[6][7] <= shreg[7];
                else if (wr_ok && ptr == 8'h86) vreg[6][6:0] <= shreg[6:0];
                else if (wr_ok && !ptr[3] && ptr[2:0] != 3'd7) vreg[ptr[2:0]] <= shreg;
              end else if (wr_ok) begin
                pbuf[ptr[3:0]] <= shreg;
                pv[ptr[3:0]] <= 1'b1;
                pbase <= ptr[7:4];
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic busy_o,
  input logic wp_i,
  input logic stop_det,
  input logic latch,
  input logic wr_stb
);
  a_r1_drive_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  a_r9_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_det));
  a_r7_no_commit_protected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(wp_i));
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> busy_o);
  a_r6_latch_by_data_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch) |-> $past(wr_stb));
endmodule

bind tw_mem_slave tw_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .busy_o(busy_o),
  .wp_i(wp_i), .stop_det(stop_det), .latch(latch), .wr_stb(wr_stb)
);

// File: tb/sim_tw_mem_slave.sv
module sim_tw_mem_slave;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sdam = 1'b1;
  logic       sda_oe, busy;
  logic [2:0] strap = 3'b101;
  logic       wp = 1'b0;
  logic [7:0] sense = 8'h3C;
  wire        sda_bus = sdam & ~sda_oe;

  tw_mem_slave #(.BUSY_CYC(400)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .wp_i(wp), .sense_i(sense), .busy_o(busy)
  );

  int nrun = 0, nfail = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  wire  [7:0] dev_w = {4'b1010, strap, 1'b0};
  wire  [7:0] dev_r = {4'b1010, strap, 1'b1};

  task automatic q();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic bstart();
    sdam = 1'b1; q(); scl = 1'b1; q(); sdam = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bstop();
    sdam = 1'b0; q(); scl = 1'b1; q(); sdam = 1'b1; q();
  endtask

  task automatic bit_out(input logic b);
    sdam = b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sdam = 1'b1; q(); scl = 1'b1; q(); ack = !sda_bus; q(); scl = 1'b0; q();
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    sdam = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1; q(); b[i] = sda_bus; q(); scl = 1'b0;
    end
    q(); sdam = mack ? 1'b0 : 1'b1; q(); scl = 1'b1; q(); q(); scl = 1'b0; q(); sdam = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input int n, output logic ok);
    logic ak;
    ok = 1'b1;
    bstart();
    send(dev_w, ak); ok &= ak;
    send(a, ak);     ok &= ak;
    for (int k = 0; k < n; k++) begin send(wbuf[k], ak); ok &= ak; end
    bstop();
  endtask

  task automatic rd(input logic [7:0] a, input int n);
    logic ak;
    bstart(); send(dev_w, ak); send(a, ak);
    bstart(); send(dev_r, ak);
    for (int k = 0; k < n; k++) recv(k < n - 1, rbuf[k]);
    bstop();
  endtask

  task automatic wait_ready();
    while (busy) @(negedge clk);
    q();
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    logic ok;
    wbuf[0] = d;
    wr(a, 1, ok);
    chk("R12 data byte acknowledged", 32'(ok), 1);
    wait_ready();
  endtask

  task automatic rd1(input string r, input logic [7:0] a, input logic [7:0] e);
    rd(a, 1);
    chk(r, 32'(rbuf[0]), 32'(e));
  endtask

  task automatic finish_all();
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R13 watchdog: actual hung expected done");
    finish_all();
  end

  initial begin
    logic ok, ak;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    q();

    // R13 reset state
    chk("R13 sda_oe after reset", 32'(sda_oe), 0);
    chk("R13 busy after reset", 32'(busy), 0);
    rd1("R13 array reads zero", 8'h00, 8'h00);
    rd1("R2 random read of 7Fh", 8'h7F, 8'h00);

    // R1 sweep over strap values
    for (int s = 0; s < 8; s++) begin
      bstart(); send({4'b1010, 3'(s), 1'b0}, ak); bstop();
      chk("R1 address match", 32'(ak), 32'(s == 5));
    end
    bstart(); send({4'b1011, strap, 1'b0}, ak); bstop();
    chk("R1 wrong device id", 32'(ak), 0);

    // R6 latch clear: writes discarded
    wr1(8'h00, 8'h55);
    chk("R6 no commit with latch clear", 32'(busy), 0);
    rd1("R6 write discarded", 8'h00, 8'h00);
    wr1(8'h86, 8'h80);
    rd1("R6 latch set by 80h", 8'h86, 8'h80);

    // R10 volatile burst
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
    wr(8'h80, 3, ok);
    chk("R10 no busy after volatile write", 32'(busy), 0);
    rd(8'h80, 3);
    chk("R10 reg 80h", 32'(rbuf[0]), 32'hA5);
    chk("R10 reg 81h", 32'(rbuf[1]), 32'h5A);
    chk("R10 reg 82h", 32'(rbuf[2]), 32'hC3);

    // R3 page-wrap sweep over every start offset
    for (int off = 0; off < 16; off++) begin
      for (int k = 0; k < 5; k++) begin
        wbuf[k] = 8'(off * 16 + k + 1);
        model[{4'h3, 4'(off + k)}] = wbuf[k];
      end
      wr({4'h3, 4'(off)}, 5, ok);
      if (off == 0) begin
        repeat (6) @(negedge clk);
        chk("R11 busy after commit", 32'(busy), 1);
        bstart(); send(dev_w, ak); bstop();
        chk("R11 address refused while busy", 32'(ak), 0);
        wait_ready();
        bstart(); send(dev_w, ak); bstop();
        chk("R11 address accepted after busy", 32'(ak), 1);
      end
      wait_ready();
    end
    rd(8'h30, 16);
    for (int k = 0; k < 16; k++)
      chk("R3 page contents", 32'(rbuf[k]), 32'(model[8'h30 + 8'(k)]));
    rd1("R3 next page untouched", 8'h40, 8'h00);

    // R4 wrap FF->00, R5 current address
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    wr(8'hFE, 2, ok); model[8'hFE] = 8'hE1; model[8'hFF] = 8'hE2;
    wait_ready();
    wbuf[0] = 8'h0A; wbuf[1] = 8'h0B;
    wr(8'h00, 2, ok); model[8'h00] = 8'h0A; model[8'h01] = 8'h0B;
    wait_ready();
    rd(8'hFE, 3);
    chk("R4 seq read FEh", 32'(rbuf[0]), 32'(model[8'hFE]));
    chk("R4 seq read FFh", 32'(rbuf[1]), 32'(model[8'hFF]));
    chk("R4 seq read wraps to 00h", 32'(rbuf[2]), 32'(model[8'h00]));
    bstart(); send(dev_r, ak); recv(1'b0, rbuf[0]); bstop();
    chk("R5 current address read", 32'(rbuf[0]), 32'(model[8'h01]));

    // R9 STOP inside a byte
    bstart(); send(dev_w, ak); send(8'h40, ak); send(8'h77, ak);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    bstop();
    repeat (6) @(negedge clk);
    chk("R9 no busy on misaligned stop", 32'(busy), 0);
    rd1("R9 location unchanged", 8'h40, 8'h00);

    // R8 block lock
    wr1(8'h86, 8'h81);
    rd1("R8 lock field written", 8'h86, 8'h81);
    wr1(8'h10, 8'h11);
    rd1("R8 low quarter locked", 8'h10, model[8'h10]);
    wr1(8'h50, 8'h66); model[8'h50] = 8'h66;
    rd1("R8 unlocked location written", 8'h50, 8'h66);
    wr1(8'h86, 8'h83);
    wr1(8'hA0, 8'h77);
    rd1("R8 upper array locked", 8'hA0, 8'h00);
    wr1(8'h80, 8'h12);
    rd1("R8 volatile never locked", 8'h80, 8'h12);
    wr1(8'h86, 8'h80);
    rd1("R6 80h leaves other bits", 8'h86, 8'h83);
    wr1(8'h86, 8'h82);
    wr1(8'h90, 8'h44); model[8'h90] = 8'h44;
    rd1("R8 mode 2 leaves upper open", 8'h90, 8'h44);
    wr1(8'h86, 8'h84);

    // R7 write protect
    wp = 1'b1;
    wr1(8'h86, 8'h00);
    rd1("R7 latch not cleared", 8'h86, 8'h84);
    wr1(8'h20, 8'h99);
    chk("R7 no commit", 32'(busy), 0);
    rd1("R7 array unchanged", 8'h20, 8'h00);
    wr1(8'h80, 8'hFF);
    rd1("R7 volatile unchanged", 8'h80, 8'h12);
    wp = 1'b0;

    // R6 clearing the latch
    wr1(8'h86, 8'h00);
    rd1("R6 00h clears latch only", 8'h86, 8'h04);
    wr1(8'h80, 8'h77);
    rd1("R6 volatile write refused", 8'h80, 8'h12);
    wr1(8'h86, 8'h05);
    rd1("R6 other value refused", 8'h86, 8'h04);

    // R12 read-only and reserved
    rd1("R12 87h reads sense", 8'h87, 8'h3C);
    sense = 8'hC7;
    rd1("R12 87h follows sense", 8'h87, 8'hC7);
    wr1(8'h86, 8'h80);
    wr1(8'h87, 8'h11);
    wr1(8'h88, 8'h22);
    rd1("R12 reserved reads zero", 8'h88, 8'h00);
    rd(8'h86, 3);
    chk("R12 seq 86h", 32'(rbuf[0]), 32'h84);
    chk("R12 87h write ignored", 32'(rbuf[1]), 32'hC7);
    chk("R12 88h", 32'(rbuf[2]), 32'h00);

    finish_all();
  end
endmodule